// File: doc/BRIEF.md
# Parallel LFSR Remainder Encoder

This block produces the check bits of a systematic cyclic-code encoder (CRC or BCH style). A message arrives as a stream of P-bit words, one word per clock when `in_valid` is high. The block divides the message polynomial, multiplied by x^R, by a fixed generator polynomial of degree R. It delivers the R-bit remainder together with a one-cycle strobe once the word marked as final has been absorbed. The generator polynomial, the word width P and an optional input pipeline stage are all fixed at elaboration.

Serial division chained P times would give a long XOR loop. This block instead keeps only the last R feedback values of the equivalent transposed serial register. Each new feedback value splits into two parts. One part depends only on the input word; the other is the parity of a fixed subset of the stored feedback values. The input part lies outside the loop, so it can be registered once without changing the result. The remainder is then formed from the stored feedback values alone.

A message of K bits, with K a multiple of P, takes K/P valid cycles. A start pulse clears the stored feedback values before the first word, or in the same cycle as it.

Top module: `plfsr_enc`

## Requirements
- R1: After a message ends, `parity_o` bit i equals the coefficient of x^i in (M(x)·x^R) mod g(x). Here M(x) is the message, and `GPOLY` bit i is the coefficient g_i, with bits 0 and R set.
- R2: Each valid cycle consumes one P-bit word. Word bit P-1 is the highest-degree bit of that word, and earlier words hold higher degrees than later ones.
- R3: `start_i` clears the stored feedback values to zero. When `start_i` and `in_valid` are high in the same cycle, that word is treated as the first word of a fresh message.
- R4: Cycles with `in_valid` low leave the division state unchanged, whatever `data_i` and `last_i` carry.
- R5: `parity_vld_o` is high for exactly one cycle after each valid word flagged by `last_i`. With `PIPE`=0 it is high one cycle after that word; with `PIPE`=1 it is high two cycles after it. It is low at all other times.
- R6: `parity_o` keeps its value from one completed message until the next one completes.
- R7: While reset is active and after its release, `parity_o` is zero and `parity_vld_o` is low until a message completes.
- R8: With `PIPE`=1 the remainder is bit-for-bit the same as with `PIPE`=0 for the same input stream. Only the timing changes, by one cycle.
- R9: `last_i` high with `in_valid` low produces no strobe and does not end the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Clears the division state for a new message |
| data_i | input | P | Message word, bit P-1 highest degree |
| in_valid | input | 1 | `data_i` carries a message word this cycle |
| last_i | input | 1 | The valid word this cycle is the final one |
| parity_o | output | R | Remainder of the latest completed message |
| parity_vld_o | output | 1 | One-cycle strobe: `parity_o` has just been updated |

## Verification
Two copies of the encoder receive the same input stream, one without the input pipeline and one with it. The first must raise its strobe one cycle after the final word and the second two cycles after it. The bench drives inputs and samples outputs on falling edges. On the falling edge right after the final word's rising edge, it expects the strobe and the correct remainder from the unpipelined copy only. One falling edge later it expects them from the pipelined copy only. One further edge later it expects both remainders to be unchanged and both strobes low. The expected remainder comes from long division of the shifted message by the generator. Every message of one to four words is swept, with idle gaps, junk data and unqualified last flags between words, and with start both separate from and merged into the first word.

// File: rtl/plfsr_pkg.sv
package plfsr_pkg;

  localparam int unsigned MAXW = 64;
  typedef logic [MAXW-1:0] vec_t;

  // Linear form of the k-th new feedback value of one parallel step.
  // Bits [r-1:0] select stored feedback values (bit j = value j+1 steps back),
  // bits [r+p-1:r] select word bits (bit r+d = data bit d).
  function automatic vec_t coef_row(vec_t gpoly, int r, int p, int k);
    vec_t win [MAXW];
    vec_t f;
    f = '0;
    for (int j = 0; j < MAXW; j++) win[j] = (j < r) ? (vec_t'(1) << j) : '0;
    for (int s = 0; s <= k; s++) begin
      f = vec_t'(1) << (r + p - 1 - s);
      for (int j = 0; j < r; j++) if (gpoly[r-1-j]) f ^= win[j];
      for (int j = MAXW - 1; j > 0; j--) win[j] = win[j-1];
      win[0] = f;
    end
    return f;
  endfunction

endpackage

// File: rtl/plfsr_rst_sync.sv
module plfsr_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/plfsr_in_stage.sv
module plfsr_in_stage #(
  parameter int unsigned R     = 3,
  parameter int unsigned P     = 3,
  parameter logic [R:0]  GPOLY = 4'b1101,
  parameter bit          PIPE  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         valid_i,
  input  logic         last_i,
  input  logic [P-1:0] data_i,
  output logic         start_o,
  output logic         valid_o,
  output logic         last_o,
  output logic [P-1:0] ucon_o
);
  localparam plfsr_pkg::vec_t GEXT = plfsr_pkg::vec_t'(GPOLY);

  logic [P-1:0] ucon_d;

  // Word-only share of each new feedback value: outside the loop.
  for (genvar k = 0; k < P; k++) begin : g_ucon
    localparam plfsr_pkg::vec_t ROW = plfsr_pkg::coef_row(GEXT, int'(R), int'(P), k);
    assign ucon_d[k] = ^(data_i & ROW[R+P-1:R]);
  end

  if (PIPE) begin : g_pipe
    logic         start_q, valid_q, last_q;
    logic [P-1:0] ucon_q;
    logic [P-1:0] ucon_n;

    always_comb begin
      ucon_n = ucon_q;
      if (valid_i) ucon_n = ucon_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= 1'b0;
        valid_q <= 1'b0;
        last_q  <= 1'b0;
        ucon_q  <= '0;
      end else begin
        start_q <= start_i;
        valid_q <= valid_i;
        last_q  <= last_i & valid_i;
        ucon_q  <= ucon_n;
      end
    end

    assign start_o = start_q;
    assign valid_o = valid_q;
    assign last_o  = last_q;
    assign ucon_o  = ucon_q;

    // R8: the pipeline stage delays every word by exactly one cycle
    assert_pipe_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && last_i) |=> (valid_o && last_o))
      else $error("pipelined final word lost");
  end else begin : g_direct
    assign start_o = start_i;
    assign valid_o = valid_i;
    assign last_o  = last_i & valid_i;
    assign ucon_o  = ucon_d;
  end
endmodule

// File: rtl/plfsr_fb_core.sv
module plfsr_fb_core #(
  parameter int unsigned R     = 3,
  parameter int unsigned P     = 3,
  parameter logic [R:0]  GPOLY = 4'b1101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         valid_i,
  input  logic [P-1:0] ucon_i,
  output logic [R-1:0] fwin_next_o
);
  localparam plfsr_pkg::vec_t GEXT = plfsr_pkg::vec_t'(GPOLY);

  logic [R-1:0] fwin_q, fwin_d, base, fwin_next;
  logic [P-1:0] fnew;
  logic         fwin_en;

  // A start in the same cycle as a word makes that word see a cleared state.
  assign base = start_i ? '0 : fwin_q;

  for (genvar k = 0; k < P; k++) begin : g_fb
    localparam plfsr_pkg::vec_t ROW = plfsr_pkg::coef_row(GEXT, int'(R), int'(P), k);
    assign fnew[k] = ucon_i[k] ^ (^(base & ROW[R-1:0]));
  end

  // Window of the R most recent feedback values, newest at index 0.
  for (genvar j = 0; j < R; j++) begin : g_win
    if (j < P) begin : g_new
      assign fwin_next[j] = fnew[P-1-j];
    end else begin : g_old
      assign fwin_next[j] = base[j-P];
    end
  end

  always_comb begin
    fwin_en = start_i | valid_i;
    fwin_d  = valid_i ? fwin_next : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fwin_q <= '0;
    else if (fwin_en) fwin_q <= fwin_d;
  end

  assign fwin_next_o = fwin_next;

  // R3: a lone start leaves the division state cleared
  assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_i) |=> (fwin_q == '0))
    else $error("state not cleared by start");

  // R4: idle cycles do not disturb the division state
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !valid_i) |=> $stable(fwin_q))
    else $error("state moved without a word");
endmodule

// File: rtl/plfsr_par_out.sv
module plfsr_par_out #(
  parameter int unsigned R     = 3,
  parameter logic [R:0]  GPOLY = 4'b1101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic         last_i,
  input  logic [R-1:0] fwin_i,
  output logic [R-1:0] parity_o,
  output logic         parity_vld_o
);
  logic [R-1:0] par_d, par_q, par_n;
  logic         done, vld_q;

  // Remainder bit i: feedback values weighted by g_0..g_i.
  always_comb begin
    par_d = '0;
    for (int i = 0; i < int'(R); i++)
      for (int j = 0; j <= i; j++)
        if (GPOLY[i-j]) par_d[i] = par_d[i] ^ fwin_i[j];
  end

  always_comb begin
    done  = valid_i & last_i;
    par_n = par_q;
    if (done) par_n = par_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= '0;
      vld_q <= 1'b0;
    end else begin
      par_q <= par_n;
      vld_q <= done;
    end
  end

  assign parity_o     = par_q;
  assign parity_vld_o = vld_q;

  // R5: strobe follows each final word
  assert_vld_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && last_i) |=> parity_vld_o)
    else $error("missing parity strobe");

  // R5 / R9: no strobe without a valid final word
  assert_vld_only_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && last_i) |=> !parity_vld_o)
    else $error("spurious parity strobe");

  // R6: remainder held between completions
  assert_parity_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && last_i) |=> $stable(parity_o))
    else $error("parity changed without completion");
endmodule

// File: rtl/plfsr_enc.sv
module plfsr_enc #(
  parameter int unsigned R     = 3,
  parameter int unsigned P     = 3,
  parameter logic [R:0]  GPOLY = 4'b1101,
  parameter bit          PIPE  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [P-1:0] data_i,
  input  logic         in_valid,
  input  logic         last_i,
  output logic [R-1:0] parity_o,
  output logic         parity_vld_o
);
  logic         rst_sync_n;
  logic         s_start, s_valid, s_last;
  logic [P-1:0] s_ucon;
  logic [R-1:0] fwin_next;

  plfsr_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  plfsr_in_stage #(.R(R), .P(P), .GPOLY(GPOLY), .PIPE(PIPE)) u_in (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .valid_i (in_valid),
    .last_i  (last_i),
    .data_i  (data_i),
    .start_o (s_start),
    .valid_o (s_valid),
    .last_o  (s_last),
    .ucon_o  (s_ucon)
  );

  plfsr_fb_core #(.R(R), .P(P), .GPOLY(GPOLY)) u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (s_start),
    .valid_i     (s_valid),
    .ucon_i      (s_ucon),
    .fwin_next_o (fwin_next)
  );

  plfsr_par_out #(.R(R), .GPOLY(GPOLY)) u_out (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .valid_i      (s_valid),
    .last_i       (s_last),
    .fwin_i       (fwin_next),
    .parity_o     (parity_o),
    .parity_vld_o (parity_vld_o)
  );
endmodule

// File: tb/plfsr_enc_test.sv
`timescale 1ns/1ps
module plfsr_enc_test;
  localparam int unsigned R = 3;
  localparam int unsigned P = 3;
  localparam logic [R:0]  G = 4'b1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, in_valid = 1'b0, last_i = 1'b0;
  logic [P-1:0] data_i = '0;
  logic [R-1:0] par0, par1;
  logic vld0, vld1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  plfsr_enc #(.R(R), .P(P), .GPOLY(G), .PIPE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .in_valid(in_valid), .last_i(last_i), .parity_o(par0), .parity_vld_o(vld0));

  plfsr_enc #(.R(R), .P(P), .GPOLY(G), .PIPE(1'b1)) uut_p (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .in_valid(in_valid), .last_i(last_i), .parity_o(par1), .parity_vld_o(vld1));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Long division of M(x)*x^3 by g(x).
  function automatic logic [2:0] ref_rem(input logic [11:0] m, input int nb);
    logic [14:0] d;
    d = {m, 3'b000};
    for (int b = nb + 2; b >= 3; b--)
      if (d[b]) d = d ^ (15'(G) << (b - 3));
    return d[2:0];
  endfunction

  // mode 0: plain; 1: gaps with junk (R4); 2: start merged with word (R3);
  // 3: gaps with unqualified last (R9)
  task automatic send_msg(input logic [11:0] m, input int nw, input int mode);
    logic [2:0] exp;
    exp = ref_rem(m, nw * 3);
    if (mode != 2) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int w = 0; w < nw; w++) begin
      data_i   = m[nw*3-1-3*w -: 3];
      start_i  = (mode == 2 && w == 0);
      in_valid = 1'b1;
      last_i   = (w == nw - 1);
      @(negedge clk);
      start_i = 1'b0; in_valid = 1'b0; last_i = 1'b0;
      if (mode[0] && w != nw - 1) begin
        data_i = ~data_i;
        last_i = (mode == 3);
        @(negedge clk);
        last_i = 1'b0;
        data_i = 3'(w + 5);
        check(!vld0 && !vld1, "R9 R4 no strobe in gap", int'(vld0) + int'(vld1), 0);
        @(negedge clk);
      end
    end
    check(vld0 == 1'b1, "R5 strobe one cycle after last", int'(vld0), 1);
    check(par0 == exp, (mode == 2) ? "R1 R2 R3 remainder merged start"
                      : (mode == 0) ? "R1 R2 remainder" : "R1 R4 remainder with gaps",
          int'(par0), int'(exp));
    check(vld1 == 1'b0, "R5 pipelined strobe not yet", int'(vld1), 0);
    @(negedge clk);
    check(vld0 == 1'b0, "R5 strobe single cycle", int'(vld0), 0);
    check(vld1 == 1'b1, "R5 pipelined strobe two cycles after last", int'(vld1), 1);
    check(par1 == exp, "R8 pipelined remainder", int'(par1), int'(exp));
    @(negedge clk);
    check(!vld0 && !vld1, "R5 strobes low afterwards", int'(vld0) + int'(vld1), 0);
    check(par0 == exp && par1 == exp, "R6 remainder held",
          int'(par0) * 8 + int'(par1), int'(exp) * 9);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(par0 == '0 && !vld0, "R7 reset state", int'(par0) + int'(vld0), 0);
    check(par1 == '0 && !vld1, "R7 reset state pipelined", int'(par1) + int'(vld1), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(par0 == '0 && !vld0 && !vld1, "R7 after release",
          int'(par0) + int'(vld0) + int'(vld1), 0);
    for (int nw = 1; nw <= 4; nw++)
      for (int m = 0; m < (1 << (3 * nw)); m++)
        send_msg(12'(m), nw, m % 4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule